// File: doc/BRIEF.md
# Configuration Phase Controller

This block steps a programmable device through the first three phases of bringing up its configuration: clearing the configuration memory, waiting for initialization, and taking in the configuration data. Configuration starts at power-on reset or whenever the active-low PROGRAM request is seen low. During clearing the controller pulls the shared INIT and DONE lines low and keeps the user I/O disabled. After each clear pass it checks PROGRAM again. If the request is still held, another pass follows.

Once clearing ends, the controller lets go of INIT and waits until the open-drain line actually reads high. Outside logic can therefore hold INIT low to delay configuration. On the first cycle INIT reads high, the three mode pins are captured and the data interface opens. Every 32-bit data word except the last is folded into a running CRC-16. The last word before the end-of-data marker carries the expected CRC. If the two agree, the controller sends a one-cycle pulse to the start-up sequencer. If they differ, it pulls INIT low again and ignores all later traffic until the next PROGRAM request.

INIT and DONE are modelled as pull-low enables, so the board-level line is low whenever any device enables its pull-down.

Top module: `cfg_phase_ctrl`

## Requirements
- R1: While `porRst` is high, and on the first cycle after it falls, the outputs show the clear phase: `initPullLow`=1, `donePullLow`=1, `ioDisable`=1, `loadEnable`=0, `cfgError`=0, `startupGo`=0 and `modeLatched`=0.
- R2: If `progN` is low at a clock edge, the next cycle is in the clear phase whatever the state was, with `cfgError`=0, `loadEnable`=0, and the running CRC and held word discarded. This takes priority over an end-of-data marker in the same cycle.
- R3: A `clearPassDone` pulse seen while `progN` is still low starts another clear pass, and `initPullLow` stays 1. Seen with `progN` high, it ends clearing: from the next cycle `initPullLow`=0 while `donePullLow` and `ioDisable` stay 1.
- R4: After INIT is released, the controller waits as long as `initSense` reads 0. During that time `loadEnable` stays 0.
- R5: At the first edge with `initSense`=1, `modePins` is copied into `modeLatched` and `loadEnable` becomes 1 in the next cycle. Later changes on `modePins` do not change `modeLatched`.
- R6: The CRC is CRC-16 with polynomial 0x8005, preset 0, no reflection and no final XOR. It takes each word's bits MSB first and covers every accepted word except the last one before the marker. The expected value is bits 15:0 of that last word, and bits 31:16 of that word are ignored.
- R7: When `dataLast` arrives and the CRC matches, `startupGo` is 1 for exactly the next cycle. After that, `loadEnable`, `donePullLow`, `ioDisable` and `initPullLow` are all 0, and DONE and I/O are handed to start-up.
- R8: When `dataLast` arrives and the CRC does not match, or no word was accepted, `cfgError`=1 and `initPullLow`=1 from the next cycle with `loadEnable`=0. Further words and markers have no effect. The error state is left only through `progN` or `porRst`.
- R9: In a cycle where `dataLast` is high, any `dataValid` word is not accepted and takes no part in the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Power-on reset, active high, asynchronous |
| progN | input | 1 | Configuration request, active low |
| initSense | input | 1 | Sensed level of the open-drain INIT line |
| modePins | input | 3 | Mode select pins |
| clearPassDone | input | 1 | Pulse from the clearing engine at the end of each memory pass |
| dataWord | input | 32 | Configuration data word |
| dataValid | input | 1 | `dataWord` holds a word this cycle |
| dataLast | input | 1 | End-of-data marker |
| initPullLow | output | 1 | Enable for the pull-down on INIT |
| donePullLow | output | 1 | Enable for the pull-down on DONE |
| ioDisable | output | 1 | Keeps the user I/O disabled |
| modeLatched | output | 3 | Captured mode value |
| loadEnable | output | 1 | Data interface is open |
| cfgError | output | 1 | CRC failure, sticky |
| startupGo | output | 1 | One-cycle handoff pulse to start-up |

## Verification
Two events can land in the same cycle: the end-of-data marker that decides pass or fail, and a PROGRAM request that restarts everything. The bench raises `progN` low in the very cycle `dataLast` is high. It then expects the clear phase with no `startupGo` pulse and no error, which shows the restart wins. A second overlap, a data word presented together with the marker, is also driven. The bench checks that the verdict is based only on the words that came before.

// File: rtl/cfg_phase_pkg.sv
package cfg_phase_pkg;

  typedef enum logic [2:0] {
    PH_CLEAR,
    PH_WAITINIT,
    PH_LOAD,
    PH_HANDOFF,
    PH_READY,
    PH_FAULT
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic crcClear;
    logic wordTake;
    logic modeLoad;
  } dp_strobe_t;

endpackage

// File: rtl/cfg_crc_path.sv
module cfg_crc_path
  import cfg_phase_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8005,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              porRst,
  input  dp_strobe_t        strobe,
  input  logic [WORD_W-1:0] dataWord,
  input  logic [MODE_W-1:0] modePins,
  output logic [MODE_W-1:0] modeLatched,
  output logic              crcMatch
);

  logic [CRC_W-1:0]  crcReg;
  logic [CRC_W-1:0]  nextCrc;
  logic [WORD_W-1:0] pendWord;
  logic              pendValid;
  logic [MODE_W-1:0] modeReg;

  // fold one word into the CRC, MSB first
  function automatic logic [CRC_W-1:0] foldWord(input logic [CRC_W-1:0] c,
                                                 input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ w[i]) r = (r << 1) ^ CRC_POLY;
      else                   r = r << 1;
    end
    return r;
  endfunction

  always_comb nextCrc = foldWord(crcReg, pendWord);

  // the newest word is held back: it is the expected value if the marker follows
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      crcReg    <= '0;
      pendWord  <= '0;
      pendValid <= 1'b0;
    end else if (strobe.crcClear) begin
      crcReg    <= '0;
      pendValid <= 1'b0;
    end else if (strobe.wordTake) begin
      if (pendValid) crcReg <= nextCrc;
      pendWord  <= dataWord;
      pendValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)               modeReg <= '0;
    else if (strobe.modeLoad) modeReg <= modePins;
  end

  assign modeLatched = modeReg;
  assign crcMatch    = pendValid && (crcReg == pendWord[CRC_W-1:0]);

  // R5: mode value only moves on its load strobe
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (porRst)
    !strobe.modeLoad |=> $stable(modeLatched));

  // R2: a clear leaves nothing to match against
  assert_clear_empty_R2: assert property (@(posedge clk) disable iff (porRst)
    strobe.crcClear |=> !crcMatch);

endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
  import cfg_phase_pkg::*;
(
  input  logic       clk,
  input  logic       porRst,
  input  logic       progN,
  input  logic       initSense,
  input  logic       clearPassDone,
  input  logic       dataValid,
  input  logic       dataLast,
  input  logic       crcMatch,
  output dp_strobe_t strobe,
  output logic       initPullLow,
  output logic       donePullLow,
  output logic       ioDisable,
  output logic       loadEnable,
  output logic       cfgError,
  output logic       startupGo
);

  phase_e phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    if (!progN) begin
      phaseNext = PH_CLEAR;
    end else begin
      unique case (phase)
        PH_CLEAR:    if (clearPassDone) phaseNext = PH_WAITINIT;
        PH_WAITINIT: if (initSense)     phaseNext = PH_LOAD;
        PH_LOAD:     if (dataLast)      phaseNext = crcMatch ? PH_HANDOFF : PH_FAULT;
        PH_HANDOFF:                     phaseNext = PH_READY;
        PH_READY:                       phaseNext = PH_READY;
        PH_FAULT:                       phaseNext = PH_FAULT;
        default:                        phaseNext = PH_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) phase <= PH_CLEAR;
    else        phase <= phaseNext;
  end

  always_comb begin
    strobe.crcClear = (phase == PH_CLEAR);
    strobe.wordTake = (phase == PH_LOAD) && dataValid && !dataLast && progN;
    strobe.modeLoad = (phase == PH_WAITINIT) && initSense && progN;
  end

  assign initPullLow = (phase == PH_CLEAR) || (phase == PH_FAULT);
  assign donePullLow = (phase != PH_READY);
  assign ioDisable   = (phase != PH_READY);
  assign loadEnable  = (phase == PH_LOAD);
  assign cfgError    = (phase == PH_FAULT);
  assign startupGo   = (phase == PH_HANDOFF);

  // R2: a PROGRAM request always lands in the clear phase
  assert_prog_restart_R2: assert property (@(posedge clk) disable iff (porRst)
    !progN |=> (initPullLow && donePullLow && !loadEnable && !cfgError));

  // R3: a pass ending with PROGRAM released lets INIT go
  assert_pass_release_R3: assert property (@(posedge clk) disable iff (porRst)
    (initPullLow && !cfgError && clearPassDone && progN) |=> !initPullLow);

  // R4: INIT held low externally keeps the machine waiting
  assert_init_hold_R4: assert property (@(posedge clk) disable iff (porRst)
    (phase == PH_WAITINIT && !initSense && progN) |=> (phase == PH_WAITINIT));

  // R7: handoff is a single-cycle pulse
  assert_handoff_pulse_R7: assert property (@(posedge clk) disable iff (porRst)
    startupGo |=> !startupGo);

  // R8: error is sticky until PROGRAM
  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (porRst)
    (cfgError && progN) |=> (cfgError && initPullLow && !loadEnable));

endmodule

// File: rtl/cfg_phase_ctrl.sv
module cfg_phase_ctrl
  import cfg_phase_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8005,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              progN,
  input  logic              initSense,
  input  logic [MODE_W-1:0] modePins,
  input  logic              clearPassDone,
  input  logic [WORD_W-1:0] dataWord,
  input  logic              dataValid,
  input  logic              dataLast,
  output logic              initPullLow,
  output logic              donePullLow,
  output logic              ioDisable,
  output logic [MODE_W-1:0] modeLatched,
  output logic              loadEnable,
  output logic              cfgError,
  output logic              startupGo
);

  dp_strobe_t strobe;
  logic       crcMatch;

  cfg_phase_fsm u_fsm (
    .clk           (clk),
    .porRst        (porRst),
    .progN         (progN),
    .initSense     (initSense),
    .clearPassDone (clearPassDone),
    .dataValid     (dataValid),
    .dataLast      (dataLast),
    .crcMatch      (crcMatch),
    .strobe        (strobe),
    .initPullLow   (initPullLow),
    .donePullLow   (donePullLow),
    .ioDisable     (ioDisable),
    .loadEnable    (loadEnable),
    .cfgError      (cfgError),
    .startupGo     (startupGo)
  );

  cfg_crc_path #(
    .WORD_W   (WORD_W),
    .CRC_W    (CRC_W),
    .CRC_POLY (CRC_POLY),
    .MODE_W   (MODE_W)
  ) u_path (
    .clk         (clk),
    .porRst      (porRst),
    .strobe      (strobe),
    .dataWord    (dataWord),
    .modePins    (modePins),
    .modeLatched (modeLatched),
    .crcMatch    (crcMatch)
  );

endmodule

// File: tb/cfg_phase_ctrl_test.sv
`timescale 1ns/1ps
module cfg_phase_ctrl_test;

  logic        clk = 1'b0;
  logic        porRst, progN, initSense, clearPassDone, dataValid, dataLast;
  logic [2:0]  modePins;
  logic [31:0] dataWord;
  logic        initPullLow, donePullLow, ioDisable, loadEnable, cfgError, startupGo;
  logic [2:0]  modeLatched;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cfg_phase_ctrl uut (
    .clk(clk), .porRst(porRst), .progN(progN), .initSense(initSense),
    .modePins(modePins), .clearPassDone(clearPassDone), .dataWord(dataWord),
    .dataValid(dataValid), .dataLast(dataLast), .initPullLow(initPullLow),
    .donePullLow(donePullLow), .ioDisable(ioDisable), .modeLatched(modeLatched),
    .loadEnable(loadEnable), .cfgError(cfgError), .startupGo(startupGo)
  );

  // fields: [31:24] seed [23:20] words [19:16] init hold [15:13] mode
  // [12] corrupt [11] program at marker [10] word with marker [9] junk upper [8] no crc word
  localparam logic [31:0] VEC [8] = '{
    {8'h11, 4'd3, 4'd0, 3'b010, 5'b00000, 8'h00},
    {8'hA7, 4'd5, 4'd3, 3'b101, 5'b10000, 8'h00},
    {8'h3C, 4'd1, 4'd1, 3'b111, 5'b00010, 8'h00},
    {8'h00, 4'd0, 4'd0, 3'b001, 5'b00000, 8'h00},
    {8'h5E, 4'd2, 4'd2, 3'b000, 5'b00001, 8'h00},
    {8'h9B, 4'd4, 4'd0, 3'b110, 5'b00100, 8'h00},
    {8'h42, 4'd2, 4'd1, 3'b011, 5'b01000, 8'h00},
    {8'h77, 4'd0, 4'd0, 3'b100, 5'b00001, 8'h00}
  };

  // reference CRC-16/0x8005, byte at a time, MSB first
  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r = c;
    for (int b = 3; b >= 0; b--) begin
      r = r ^ {w[b*8 +: 8], 8'h00};
      for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h8005) : (r << 1);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runVector(input logic [31:0] v);
    logic [7:0]  seed = v[31:24];
    int          n = int'(v[23:20]);
    int          hold = int'(v[19:16]);
    logic [2:0]  mode = v[15:13];
    logic        corrupt = v[12], progEnd = v[11], wordAtEnd = v[10];
    logic        junkUp = v[9], noCrc = v[8];
    logic [15:0] crc = 16'h0;
    logic [15:0] crcPrev = 16'h0;
    logic [31:0] lastWord = 32'h0;
    int          sent = 0;
    logic        expPass;
    progN = 1'b0; step();
    check("R2", initPullLow, 1, "init pulled on request");
    progN = 1'b1; clearPassDone = 1'b1; initSense = 1'b0; step();
    clearPassDone = 1'b0;
    check("R3", {initPullLow, donePullLow, ioDisable}, 3'b011, "release after pass");
    for (int h = 0; h < hold; h++) begin
      step();
      check("R4", loadEnable, 0, "waiting on INIT");
    end
    initSense = 1'b1; modePins = mode; step();
    check("R5", {loadEnable, modeLatched}, {1'b1, mode}, "mode capture");
    modePins = ~mode;
    for (int k = 0; k < n; k++) begin
      dataWord = {seed, 8'(k), ~seed, 8'(k * 37 + 1)};
      dataValid = 1'b1; step();
      crcPrev = crc; lastWord = dataWord; crc = refCrc(crc, dataWord); sent++;
    end
    if (!noCrc) begin
      dataWord = {junkUp ? 16'hBEEF : 16'h0000, crc ^ (corrupt ? 16'h0008 : 16'h0)};
      dataValid = 1'b1; step();
      crcPrev = crc; lastWord = dataWord; sent++;
    end
    // R6: expected = CRC over all but the last word, compared with its low half
    expPass = (sent > 0) && (crcPrev == lastWord[15:0]);
    dataValid = wordAtEnd; dataWord = 32'hDEAD_0000;
    dataLast = 1'b1;
    if (progEnd) progN = 1'b0;
    step();
    dataLast = 1'b0; dataValid = 1'b0;
    if (progEnd) begin
      check("R2", {startupGo, cfgError, initPullLow}, 3'b001, "PROGRAM beats marker");
      progN = 1'b1;
    end else if (expPass) begin
      check(wordAtEnd ? "R9" : "R7", {startupGo, cfgError}, 2'b10, "handoff on match");
    end else begin
      check("R8", {startupGo, cfgError, initPullLow}, 3'b011, "error on mismatch");
    end
    check("R5", modeLatched, mode, "mode held");
    step();
    check("R7", startupGo, 0, "single pulse");
    if (!progEnd && expPass)
      check("R7", {loadEnable, donePullLow, ioDisable, initPullLow}, 4'b0, "handed over");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    porRst = 1'b1; progN = 1'b1; initSense = 1'b0; modePins = 3'b101;
    clearPassDone = 1'b0; dataWord = '0; dataValid = 1'b0; dataLast = 1'b0;
    step();
    check("R1", {initPullLow, donePullLow, ioDisable, loadEnable, cfgError, startupGo},
          6'b111000, "reset outputs");
    check("R1", modeLatched, 0, "reset mode");
    porRst = 1'b0; step();
    check("R1", {initPullLow, donePullLow, ioDisable, loadEnable}, 4'b1110, "after reset");

    for (int i = 0; i < 8; i++) runVector(VEC[i]);

    // R3: pass ends while PROGRAM still low -> another pass
    progN = 1'b0; clearPassDone = 1'b1; step();
    clearPassDone = 1'b0;
    check("R3", initPullLow, 1, "pass repeated");
    progN = 1'b1; step();
    check("R3", initPullLow, 1, "awaiting next pass");

    // R8: after a failure, words and markers are ignored
    runVector({8'hC4, 4'd2, 4'd0, 3'b010, 5'b10000, 8'h00});
    for (int k = 0; k < 3; k++) begin
      dataValid = 1'b1; dataWord = 32'h0; dataLast = (k == 2); step();
      check("R8", {cfgError, initPullLow, loadEnable, startupGo}, 4'b1100, "sticky error");
    end
    dataValid = 1'b0; dataLast = 1'b0;
    progN = 1'b0; step();
    check("R8", cfgError, 0, "PROGRAM clears error");
    progN = 1'b1;

    // R8: power-on reset also leaves the error state
    runVector({8'h19, 4'd1, 4'd0, 3'b001, 5'b10000, 8'h00});
    porRst = 1'b1; step(); porRst = 1'b0;
    check("R8", {cfgError, initPullLow}, 2'b01, "reset clears error");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule